// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

A register-mapped general-purpose I/O block with 32 lines, organised as four 8-bit ports. Software sets each line's output enable and output value, reads back the synchronised pin levels, and picks per line whether a rising edge, a falling edge, both edges or nothing is recorded. Recorded edges collect in a pending-status word. Software clears that word one bit at a time by writing ones. A routing mask for each CPU selects which pending lines drive that CPU's interrupt output.

The register port is a plain synchronous strobe interface with no back-pressure. A write is taken on the clock edge where `bus_wr` is high. For a read, `bus_rd` is held high for one edge, and the data appears on `bus_rdata` after that edge and stays for one cycle. In all other cycles `bus_rdata` is zero. Every access is a full 32-bit word at a word address.

A static strap, `swap_order`, selects one of two layouts. With the strap low, words are little-endian by port. With the strap high, every per-line word is byte-reversed, so port 0 sits in the top byte. In that mode the two ports that share an edge-select word also trade places.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the following registers read zero: output enable, output data, pending status and both edge-select words. Every CPU mask reads all ones, and every `irq` bit is low.
- R2: A line whose 2-bit edge field is 00 never sets its pending bit, whatever its pin does.
- R3: The edge field codes are 01 for falling, 10 for rising and 11 for both. Pin inputs pass through a two-flop synchroniser. The pending bit, and so `irq`, goes high at the third rising clock edge after the pin changes, and not before.
- R4: The edge-select words are at word addresses 4 (low) and 5 (high). With `swap_order` low, line n's field sits at bits 2n+1:2n of the 64-bit value {word5, word4}.
- R5: With `swap_order` high, line n (port p=n/8, pin q=n%8) has its field at position 2*(8*(p XOR 1)+q) of {word5, word4}.
- R6: The per-line words are output enable (address 0), output data (address 1), pin input (address 2, read-only), pending status (address 3) and the CPU masks. With `swap_order` low, line n is bit n. With `swap_order` high, each word is byte-reversed, so line n is at bit 8*(3-n/8)+n%8.
- R7: Writing a 1 to a pending-status bit clears it. Writing 0 leaves it unchanged.
- R8: If an edge is detected on the same clock edge as a clearing write to that line, the bit stays pending.
- R9: CPU c's mask is at word address 8+c. `irq[c]` is high exactly when some pending line has its bit set in that mask.
- R10: The output enable word drives `pin_oe` (1 = output). The output data word drives `pin_o`. The pin input word reads the synchronised `pin_i`.
- R11: A read returns data only in the cycle after the read strobe. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_order | input | 1 | Strap: 1 selects the byte-reversed, port-swapped layout |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_i | input | 32 | Pin levels |
| pin_o | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | NCPU | One interrupt per CPU |

## Verification
The bench measures the latency from pin to interrupt cycle by cycle. A synchroniser that is too short or too long would assert `irq` a cycle early or a cycle late. It lines up a clearing write with a fresh edge on a line that is already pending. A design where the clear wins would drop an interrupt. In swapped mode it checks the edge-field slot, the byte position in the pending word and the effect of a routing-mask write. An address-mapping error there would arm the wrong line or raise the wrong CPU. It also toggles a line whose edge field is 00, which must stay silent, and writes zero to the pending word, which must change nothing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PORT_W  = 8;
  localparam int N_PORTS = 4;
  localparam int LINES   = PORT_W * N_PORTS;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Present a per-line word in bus order; the mapping is its own inverse.
  function automatic logic [LINES-1:0] lane_order(input logic [LINES-1:0] w,
                                                  input logic swap);
    logic [LINES-1:0] r;
    for (int p = 0; p < N_PORTS; p++)
      r[p*PORT_W +: PORT_W] = w[(N_PORTS-1-p)*PORT_W +: PORT_W];
    return swap ? r : w;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0][1:0] mode_i,
  input  logic [W-1:0]      rise_i,
  input  logic [W-1:0]      fall_i,
  input  logic [W-1:0]      clr_i,
  output logic [W-1:0]      pend_o
);
  logic [W-1:0] hit, armed, pend_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    assign armed[i] = (mode_i[i] != EDGE_OFF);
    assign hit[i]   = (rise_i[i] && (mode_i[i] == EDGE_RISE || mode_i[i] == EDGE_BOTH)) ||
                      (fall_i[i] && (mode_i[i] == EDGE_FALL || mode_i[i] == EDGE_BOTH));
  end

  // A new edge overrides a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | hit;
  end

  assign pend_o = pend_q;

  p_off_never_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(armed)) == '0));
  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_i & ~hit) & pend_q) == '0));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit) & ~pend_q) == '0));
endmodule

// File: rtl/gpio_cpu_route.sv
module gpio_cpu_route #(
  parameter int W    = 32,
  parameter int NCPU = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCPU-1:0]         wr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [W-1:0]            pend_i,
  output logic [NCPU-1:0][W-1:0]  mask_o,
  output logic [NCPU-1:0]         irq_o
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '1;
      else if (wr_i[c]) mask_q <= wdata_i;
    end

    assign mask_o[c] = mask_q;
    assign irq_o[c]  = |(pend_i & mask_q);

    p_zero_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i[c] && wdata_i == '0) |=> !irq_o[c]);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int ADDR_W    = 4,
  parameter int MASK_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_order,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_i,
  output logic [31:0]       pin_o,
  output logic [31:0]       pin_oe,
  output logic [NCPU-1:0]   irq
);
  localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_EDGE0 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MASK0 = ADDR_W'(MASK_BASE);

  logic [LINES-1:0]            oe_q, dout_q, level, rise, fall, pend, clr;
  logic [LINES-1:0]            wnat;
  logic [LINES-1:0][1:0]       mode_q;
  logic [LINES-1:0][4:0]       slot_of;
  logic [2*LINES-1:0]          edge_flat;
  logic [NCPU-1:0]             mask_wr;
  logic [NCPU-1:0][LINES-1:0]  masks;
  logic [31:0]                 rd_mux, rdata_q;

  assign wnat = lane_order(bus_wdata, swap_order);

  // Output enable and output data words.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q   <= '0;
      dout_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_OE)   oe_q   <= wnat;
      if (bus_addr == A_DOUT) dout_q <= wnat;
    end
  end
  assign pin_oe = oe_q;
  assign pin_o  = dout_q;

  // Edge-select slot per line: the strap swaps neighbouring ports.
  for (genvar i = 0; i < LINES; i++) begin : g_slot
    assign slot_of[i] = 5'(i) ^ {1'b0, swap_order, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (bus_wr)
      for (int i = 0; i < LINES; i++)
        if (bus_addr == A_EDGE0 + ADDR_W'(slot_of[i][4]))
          mode_q[i] <= bus_wdata[{slot_of[i][3:0], 1'b0} +: 2];
  end

  always_comb
    for (int s = 0; s < LINES; s++)
      edge_flat[2*s +: 2] = mode_q[5'(s) ^ {1'b0, swap_order, 3'b000}];

  gpio_pin_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  assign clr = (bus_wr && bus_addr == A_PEND) ? wnat : '0;

  gpio_edge_status #(.W(LINES)) u_status (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q),
    .rise_i(rise), .fall_i(fall), .clr_i(clr), .pend_o(pend)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_mwr
    assign mask_wr[c] = bus_wr && (bus_addr == A_MASK0 + ADDR_W'(c));
  end

  gpio_cpu_route #(.W(LINES), .NCPU(NCPU)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr), .wdata_i(wnat),
    .pend_i(pend), .mask_o(masks), .irq_o(irq)
  );

  // Read path.
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_OE)                        rd_mux = lane_order(oe_q, swap_order);
    else if (bus_addr == A_DOUT)                 rd_mux = lane_order(dout_q, swap_order);
    else if (bus_addr == A_PIN)                  rd_mux = lane_order(level, swap_order);
    else if (bus_addr == A_PEND)                 rd_mux = lane_order(pend, swap_order);
    else if (bus_addr == A_EDGE0)                rd_mux = edge_flat[31:0];
    else if (bus_addr == A_EDGE0 + ADDR_W'(1))   rd_mux = edge_flat[63:32];
    for (int c = 0; c < NCPU; c++)
      if (bus_addr == A_MASK0 + ADDR_W'(c))      rd_mux = lane_order(masks[c], swap_order);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? rd_mux : '0;
  end
  assign bus_rdata = rdata_q;

  p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_order = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_i = '0;
  logic [31:0] bus_rdata, pin_o, pin_oe;
  logic [NCPU-1:0] irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NCPU(NCPU), .ADDR_W(4), .MASK_BASE(8)) uut (
    .clk(clk), .rst_n(rst_n), .swap_order(swap_order),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reset_dut(input logic sw);
    @(negedge clk);
    rst_n = 1'b0; swap_order = sw; pin_i = '0; bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    reset_dut(1'b0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    rd(4'd0, d); check("R1 oe word", d, 32'h0);
    rd(4'd3, d); check("R1 pending", d, 32'h0);
    rd(4'd4, d); check("R1 edge lo", d, 32'h0);
    rd(4'd5, d); check("R1 edge hi", d, 32'h0);
    rd(4'd8, d); check("R1 mask0", d, 32'hFFFF_FFFF);
    rd(4'd9, d); check("R1 mask1", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_rise_latency();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd4, 32'h0000_0008);            // line 1 rising
    @(negedge clk); pin_i[1] = 1'b1;    // R3: change before next rising edge
    @(negedge clk);
    @(negedge clk); check("R3 no irq after two edges", 32'(irq), 32'h0);
    @(negedge clk); check("R3 irq at third edge", 32'(irq), 32'h3);
    rd(4'd3, d); check("R3 rising pending", d, 32'h0000_0002);
  endtask

  task automatic t_fall_and_off();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd4, 32'h0000_0C48);            // line1 rise, line3 fall, line5 both, line6 off
    set_pins(32'h0000_004A);            // up on 1,3,6
    rd(4'd3, d); check("R3 rise sets only rising line", d, 32'h0000_0002);
    wr(4'd3, 32'hFFFF_FFFF);
    set_pins(32'h0000_0000);            // down on 1,3,6
    rd(4'd3, d); check("R3 fall sets only falling line", d, 32'h0000_0008);
    wr(4'd3, 32'hFFFF_FFFF);
    set_pins(32'h0000_0020);
    rd(4'd3, d); check("R3 both-edge rise", d, 32'h0000_0020);
    wr(4'd3, 32'hFFFF_FFFF);
    set_pins(32'h0000_0000);
    rd(4'd3, d); check("R3 both-edge fall", d, 32'h0000_0020);
    wr(4'd3, 32'hFFFF_FFFF);
    set_pins(32'h0000_0040); set_pins(32'h0000_0000);
    rd(4'd3, d); check("R2 disabled line silent", d, 32'h0);
    check("R2 irq low", 32'(irq), 32'h0);
  endtask

  task automatic t_high_word();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd5, 32'h0000_0004);            // line 17 falling
    rd(4'd5, d); check("R4 edge hi readback", d, 32'h0000_0004);
    rd(4'd4, d); check("R4 edge lo untouched", d, 32'h0);
    set_pins(32'h0002_0000);
    rd(4'd3, d); check("R4 line17 rise ignored", d, 32'h0);
    set_pins(32'h0000_0000);
    rd(4'd3, d); check("R4 line17 fall pending", d, 32'h0002_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd4, 32'h0000_0028);            // lines 1,2 rising
    set_pins(32'h0000_0006);
    rd(4'd3, d); check("R7 both pending", d, 32'h0000_0006);
    wr(4'd3, 32'h0);
    rd(4'd3, d); check("R7 zero write no effect", d, 32'h0000_0006);
    wr(4'd3, 32'h0000_0002);
    rd(4'd3, d); check("R7 one clears only its bit", d, 32'h0000_0004);
    check("R7 irq still high", 32'(irq), 32'h3);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd4, 32'h0000_0300);            // line 4 both
    set_pins(32'h0000_0010);
    rd(4'd3, d); check("R8 setup pending", d, 32'h0000_0010);
    @(negedge clk); pin_i = '0;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h0000_0010;
    @(negedge clk); bus_wr = 1'b0;
    rd(4'd3, d); check("R8 edge beats clear", d, 32'h0000_0010);
    wr(4'd3, 32'h0000_0010);
    rd(4'd3, d); check("R8 later clear works", d, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd4, 32'h0000_0020);            // line 2 rising
    set_pins(32'h0000_0004);
    wr(4'd8, 32'h0000_0004);
    wr(4'd9, 32'h0);
    check("R9 only cpu0", 32'(irq), 32'h1);
    wr(4'd9, 32'h0000_0004);
    check("R9 both cpus", 32'(irq), 32'h3);
    wr(4'd8, 32'hFFFF_FFFB);
    check("R9 cpu0 masked", 32'(irq), 32'h2);
    rd(4'd9, d); check("R9 mask1 readback", d, 32'h0000_0004);
  endtask

  task automatic t_io_and_map();
    logic [31:0] d;
    reset_dut(1'b0);
    wr(4'd0, 32'hF0F0_0F0F); check("R10 pin_oe", pin_oe, 32'hF0F0_0F0F);
    wr(4'd1, 32'h1234_5678); check("R10 pin_o", pin_o, 32'h1234_5678);
    set_pins(32'hCAFE_BABE);
    rd(4'd2, d); check("R10 pin read", d, 32'hCAFE_BABE);
    rd(4'd7, d); check("R11 unmapped 7", d, 32'h0);
    rd(4'd15, d); check("R11 unmapped 15", d, 32'h0);
    @(negedge clk); check("R11 idle rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_swapped();
    logic [31:0] d;
    reset_dut(1'b1);
    wr(4'd0, 32'h0000_00AB); check("R6 swapped pin_oe", pin_oe, 32'hAB00_0000);
    rd(4'd0, d); check("R6 swapped oe readback", d, 32'h0000_00AB);
    wr(4'd4, 32'h0000_0002);            // slot 0 -> line 8 rising
    rd(4'd4, d); check("R5 edge lo readback", d, 32'h0000_0002);
    set_pins(32'h0000_0001);
    rd(4'd3, d); check("R5 line0 not armed", d, 32'h0);
    set_pins(32'h0000_0101);
    rd(4'd3, d); check("R5 R6 line8 pending swapped", d, 32'h0001_0000);
    wr(4'd8, 32'h0000_0100);            // internal bit 16 only
    check("R6 swapped mask excludes line8", 32'(irq), 32'h2);
    wr(4'd8, 32'h0001_0000);
    check("R6 swapped mask selects line8", 32'(irq), 32'h3);
    wr(4'd3, 32'h0001_0000);
    rd(4'd3, d); check("R6 swapped clear", d, 32'h0);
    set_pins(32'h1234_5678);
    rd(4'd2, d); check("R6 swapped pin read", d, 32'h7856_3412);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset_state();
    t_rise_latency();
    t_fall_and_off();
    t_high_word();
    t_w1c();
    t_set_wins();
    t_route();
    t_io_and_map();
    t_swapped();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule